// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible register file of a clock control unit. It holds the PLL control words, bus divider settings, DRAM clock configuration and the peripheral clock words. Each register is a 32-bit word on a plain register bus with a byte address, write and read strobes, write data, registered read data and two event flags. It produces no clocks. The real clock hardware elsewhere takes its settings from these words.

Each write passes through a transform before it is stored. A PLL word written with its enable bit set reads back with its lock bit already set. The update-request bits of the DDR1 PLL word and of the DRAM configuration word are always stored as zero, so they read as self-clearing. Addresses from 0x324 to the end of the 1 KiB window have no storage. Reads there return zero and writes there raise an error pulse. A write to any other in-range word without special handling stores the value unchanged and raises an "unimplemented" pulse.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset every word reads its fixed default: 0x000=0x00001000, 0x008=0x00035514, 0x010/0x018/0x030/0x038/0x048=0x03006207, 0x020=0x00001000, 0x028/0x02C=0x00041811, 0x034=0x00001811, 0x040=0x00000515, 0x04C=0x00001800, 0x054=0x00001010, 0x058=0x01000000, 0x0F0=0x00000001, 0x0F8=0x0CCCA000, 0x310=0x0000000F. Every other word below 0x324 reads 0.
- R2: The PLL words are at byte offsets 0x00, 0x08, 0x10, 0x18, 0x20, 0x28, 0x2C, 0x30, 0x34, 0x38, 0x40, 0x48 and 0x4C. A write to one of them with bit 31 (enable) set stores bit 28 (lock) as 1.
- R3: A write to a PLL word with bit 31 clear stores bit 28 exactly as written. Apart from bit 28, and bit 30 of 0x4C, every bit of a PLL word is stored as written.
- R4: A write to 0x4C always stores bit 30 as 0.
- R5: A write to 0x0F4 always stores bit 16 as 0 and stores every other bit as written.
- R6: A write to any other word below 0x324 stores the value unchanged. The `unimp` output is high for exactly the one cycle after that write.
- R7: Reads at byte offsets 0x324 to 0x3FC return 0. Writes there change no stored word, and the `err` output is high for exactly the one cycle after the write.
- R8: The word index is the byte address divided by 4. `rd_data` takes the addressed value in the cycle after `rd_en` and holds it while `rd_en` is low. A read and a write to the same word in the same cycle return the value held before the write.
- R9: Writes to PLL words and to 0x0F4 raise neither `err` nor `unimp`, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 10 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| err | output | 1 | Pulse after a write to the out-of-range area |
| unimp | output | 1 | Pulse after a write to a word without special handling |

## Verification
The hardest case to reach from the ports is a transform that interacts with the raw value, for example a DDR1 PLL write with both the enable bit and the update bit set while bit 28 is already clear or already set. Random data sets each of these bits only half the time, and random addresses seldom land on the few special words. The stimulus therefore mixes directed writes that set every bit combination on 0x4C and 0x0F4 with random traffic across the whole window, and it reads every word back against a bench model. A simultaneous read and write to one word is also driven directly to expose read-before-write ordering.

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
  parameter int ADDR_W    = 10,
  parameter int LIMIT_OFS = 'h324
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              err,
  output logic              unimp
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int NREG  = LIMIT_OFS / 4;
  localparam logic [IDX_W-1:0] IDX_DDR1 = IDX_W'('h4C / 4);
  localparam logic [IDX_W-1:0] IDX_DCFG = IDX_W'('hF4 / 4);
  localparam int EN_BIT   = 31;
  localparam int LOCK_BIT = 28;
  localparam int DDR1_UPD = 30;
  localparam int DCFG_UPD = 16;

  logic [31:0] mem [NREG];
  logic [IDX_W-1:0] idx;
  logic in_rng, pll_hit, dcfg_hit;
  logic [31:0] stored;

  function automatic logic is_pll(input logic [IDX_W-1:0] i);
    case (int'(i) * 4)
      'h00, 'h08, 'h10, 'h18, 'h20, 'h28, 'h2C,
      'h30, 'h34, 'h38, 'h40, 'h48, 'h4C: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] reset_word(input int i);
    case (i * 4)
      'h000, 'h020:                      return 32'h0000_1000;
      'h008:                             return 32'h0003_5514;
      'h010, 'h018, 'h030, 'h038, 'h048: return 32'h0300_6207;
      'h028, 'h02C:                      return 32'h0004_1811;
      'h034:                             return 32'h0000_1811;
      'h040:                             return 32'h0000_0515;
      'h04C:                             return 32'h0000_1800;
      'h054:                             return 32'h0000_1010;
      'h058:                             return 32'h0100_0000;
      'h0F0:                             return 32'h0000_0001;
      'h0F8:                             return 32'h0CCC_A000;
      'h310:                             return 32'h0000_000F;
      default:                           return 32'h0;
    endcase
  endfunction

  assign idx      = addr[ADDR_W-1:2];
  assign in_rng   = int'(idx) < NREG;
  assign pll_hit  = is_pll(idx);
  assign dcfg_hit = idx == IDX_DCFG;

  always_comb begin
    stored = wr_data;
    if (pll_hit && wr_data[EN_BIT]) stored[LOCK_BIT] = 1'b1;
    if (idx == IDX_DDR1)            stored[DDR1_UPD] = 1'b0;
    if (dcfg_hit)                   stored[DCFG_UPD] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= reset_word(i);
      rd_data <= '0;
      err     <= 1'b0;
      unimp   <= 1'b0;
    end else begin
      if (wr_en && in_rng) mem[idx] <= stored;
      if (rd_en) rd_data <= in_rng ? mem[idx] : 32'h0;
      err   <= wr_en && !in_rng;
      unimp <= wr_en && in_rng && !pll_hit && !dcfg_hit;
    end
  end

  AST_LOCK_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pll_hit && wr_data[EN_BIT]) |=> mem[$past(idx)][LOCK_BIT]); // R2
  AST_DDR1_UPD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_DDR1) |=> !mem[IDX_DDR1][DDR1_UPD]); // R4
  AST_DCFG_UPD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dcfg_hit) |=> !mem[IDX_DCFG][DCFG_UPD]); // R5
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_rng) |=> rd_data == 32'h0); // R7
  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_en)); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && unimp)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R8
endmodule

// File: tb/clkctl_regbank_test.sv
module clkctl_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 'h324 / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic err, unimp;
  logic [31:0] model [NREG];
  int tests = 0, fails = 0;

  clkctl_regbank uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .err(err), .unimp(unimp));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic m_pll(input int ofs);
    return ofs inside {'h00,'h08,'h10,'h18,'h20,'h28,'h2C,'h30,'h34,'h38,'h40,'h48,'h4C};
  endfunction

  function automatic logic [31:0] m_reset(input int ofs);
    case (ofs)
      'h000, 'h020: return 32'h00001000;
      'h008: return 32'h00035514;
      'h010, 'h018, 'h030, 'h038, 'h048: return 32'h03006207;
      'h028, 'h02C: return 32'h00041811;
      'h034: return 32'h00001811;
      'h040: return 32'h00000515;
      'h04C: return 32'h00001800;
      'h054: return 32'h00001010;
      'h058: return 32'h01000000;
      'h0F0: return 32'h00000001;
      'h0F8: return 32'h0CCCA000;
      'h310: return 32'h0000000F;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_store(input int ofs, input logic [31:0] v);
    logic [31:0] r = v;
    if (m_pll(ofs) && v[31]) r[28] = 1'b1;
    if (ofs == 'h4C) r[30] = 1'b0;
    if (ofs == 'hF4) r[16] = 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input int ofs, input logic [31:0] v);
    logic in_rng = ofs < 'h324;
    @(negedge clk);
    addr = 10'(ofs); wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 err", {31'b0, err}, {31'b0, !in_rng});
    check("R6/R9 unimp", {31'b0, unimp},
          {31'b0, in_rng && !m_pll(ofs) && ofs != 'hF4});
    if (in_rng) model[ofs/4] = m_store(ofs, v);
    @(negedge clk);
    check("R6/R7 pulse width", {30'b0, err, unimp}, 32'h0);
  endtask

  task automatic do_read(input int ofs, input string req);
    @(negedge clk);
    addr = 10'(ofs); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rd_data, ofs < 'h324 ? model[ofs/4] : 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NREG; i++) model[i] = m_reset(i*4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 defaults everywhere
    for (int i = 0; i < NREG; i++) do_read(i*4, "R1 reset value");
    do_read('h324, "R7 read oor");
    do_read('h3FC, "R7 read oor");
    // R2 lock forced on enable, every PLL word
    foreach (model[i]) if (m_pll(i*4)) begin
      do_write(i*4, 32'h8000_0123 | (32'(i) << 8));
      do_read(i*4, "R2 lock on enable");
    end
    // R3 no enable: bit 28 as written
    do_write('h08, 32'h0000_5A5A); do_read('h08, "R3 lock clear kept");
    do_write('h10, 32'h1000_0001); do_read('h10, "R3 lock set kept");
    // R4 DDR1 update bit, all combinations
    for (int k = 0; k < 8; k++) begin
      do_write('h4C, {k[2], k[1], 1'b0, k[0], 28'h0ABCDEF});
      do_read('h4C, "R4 ddr1 update clear");
    end
    // R5 DRAM cfg update bit
    do_write('hF4, 32'hFFFF_FFFF); do_read('hF4, "R5 dram update clear");
    do_write('hF4, 32'h0001_0000); do_read('hF4, "R5 dram update clear");
    // R6 plain word
    do_write('h58, 32'hDEAD_BEEF); do_read('h58, "R6 plain store");
    // R7 out of range write leaves storage untouched
    do_write('h324, 32'hFFFF_FFFF); do_read('h324, "R7 read oor");
    do_read('h000, "R7 no alias"); do_read('h320, "R7 no alias");
    // R8 simultaneous read and write returns old value
    @(negedge clk);
    addr = 10'h058; wr_data = 32'h1234_5678; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R8 read before write", rd_data, model['h58/4]);
    model['h58/4] = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R8 hold without rd_en", rd_data, 32'hDEAD_BEEF);
    do_read('h58, "R8 new value");
    // random traffic
    for (int n = 0; n < 600; n++) begin
      int ofs = int'($urandom_range(0, 255)) * 4;
      if ($urandom_range(0, 1) == 1) do_write(ofs, $urandom());
      else do_read(ofs, "R2-R7 random read");
    end
    for (int i = 0; i < NREG; i++) do_read(i*4, "R6 final sweep");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule